// File: doc/BRIEF.md
# Stream Prefetch Data Buffer

This block sits beside a first-level cache and turns a predicted sequence of block addresses into data that is ready before the processor asks for it. Predicted addresses enter a first-in first-out address queue. From the head of that queue the block issues fetches, tagged with a buffer slot number, into a small fully associative set of block slots. Responses may return in any order. A processor miss probes the slots. A filled slot that matches is returned at once and freed.

The block limits how far ahead it runs. It counts the slots that are waiting for data or holding data, and it stops issuing when that count reaches a lookahead limit. Each hit therefore lets exactly one more address be fetched, so the stream advances at the rate the processor consumes it. Several fetches can be in flight at once, which overlaps misses that would otherwise be serial.

Invalidations remove matching slots. A slot whose fetch is still in flight when it is removed stays reserved until its response comes back, and that response is then thrown away. A probe that matches nothing, neither in the slots nor in the queue, means the prediction has gone wrong. The block then discards the whole stream.

Top module: `spb_stream_buffer`

## Requirements
- R1: While reset is active and right after it is released, `str_ready` is 1, and `req_valid` and `lk_hit` are 0.
- R2: Fetches are issued strictly in the order addresses were accepted on the stream input. `req_tag` is the lowest-numbered free slot.
- R3: `req_valid` is 1 exactly when three things hold: the queue is not empty, a free slot exists, and the number of waiting plus filled slots is below LOOKAHEAD (default 8 of 12 slots). An issue happens when `req_valid` and `req_ready` are both 1. It pops the queue head and the slot starts waiting.
- R4: A response whose `rsp_tag` names a waiting slot fills that slot with `rsp_data`. A response naming a free or filled slot has no effect.
- R5: A probe that matches a filled slot raises `lk_hit` in the same cycle, with that slot's data on `lk_data`. The lowest-numbered matching slot is used and becomes free on the next edge. A later probe of the same address then misses.
- R6: Freeing a slot through a hit lowers the lookahead count on the next edge, so a held-back fetch can issue in the following cycle.
- R7: An invalidate frees a matching filled slot. It marks a matching waiting slot as dropped. A dropped slot is neither live nor free, and it becomes free when its response arrives, without being filled. If the invalidate and the response reach a waiting slot in the same cycle, the slot becomes free.
- R8: A probe that matches no waiting or filled slot and no queued address flushes the stream. The queue is emptied, filled slots are freed and waiting slots are dropped. An address accepted in the same cycle becomes the only queue entry. A probe that matches a waiting slot or a queued address returns no hit and causes no flush.
- R9: `str_ready` is 1 exactly when the queue holds fewer than QDEPTH (default 16) addresses. An address presented while it is 0 is not taken.
- R10: If an issue happens in the same cycle as a flush, or as an invalidate of the issued address, the issued slot starts out dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| str_valid | input | 1 | Predicted address offered |
| str_addr | input | AW | Predicted block address |
| str_ready | output | 1 | Queue can take an address |
| req_valid | output | 1 | Fetch request valid |
| req_addr | output | AW | Address to fetch |
| req_tag | output | TW | Slot that will receive the data |
| req_ready | input | 1 | Fetch request accepted |
| rsp_valid | input | 1 | Fetch response valid |
| rsp_tag | input | TW | Slot the response belongs to |
| rsp_data | input | DW | Returned block data |
| lk_valid | input | 1 | Processor miss probe valid |
| lk_addr | input | AW | Probed address |
| lk_hit | output | 1 | Probe served from the buffer |
| lk_data | output | DW | Data for a hit |
| inv_valid | input | 1 | Invalidate valid |
| inv_addr | input | AW | Address to invalidate |

## Verification
The bench targets the collisions of events on one slot. These include an invalidate that meets the response in the same cycle, an issue that meets a flush or an invalidate of its own address, and a late response to a dropped slot. A design that fills a dropped slot would later return stale data as a hit. A design that frees the slot too early would hand the old response to a new fetch. The bench also makes probes hit waiting slots and queued addresses, because a design that flushes on those would throw away a healthy stream. It lets the lookahead limit bind while hits are pending, so a design that miscounts dropped slots stalls or overruns the limit.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_WAIT = 2'd1,
    SL_FULL = 2'd2,
    SL_DROP = 2'd3
  } slot_st_e;
endpackage

// File: rtl/spb_addr_queue.sv
module spb_addr_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  input  logic          clear,
  input  logic [AW-1:0] probe_addr,
  output logic [AW-1:0] head_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          probe_hit
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, wr_idx;
  logic [CW-1:0] cnt_q, cnt_d;

  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = mem[rd_q];
  // A clear rewinds the write pointer to the read pointer, so a push in the same cycle lands at the head.
  assign wr_idx    = clear ? rd_q : wr_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_idx;
    cnt_d = clear ? '0 : cnt_q;
    if (pop && !clear) begin
      rd_d  = rd_q + PW'(1);
      cnt_d = cnt_d - CW'(1);
    end
    if (push) begin
      wr_d  = wr_idx + PW'(1);
      cnt_d = cnt_d + CW'(1);
    end
  end

  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ({1'b0, PW'(PW'(i) - rd_q)} < cnt_q && mem[i] == probe_addr) probe_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_addr;
  end
endmodule

// File: rtl/spb_slot_array.sv
module spb_slot_array
  import spb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int ENTRIES = 12,
  localparam int TW     = $clog2(ENTRIES),
  localparam int CW     = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_fire,
  input  logic [AW-1:0] iss_addr,
  input  logic          flush,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  input  logic [DW-1:0] rsp_data,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          free_any,
  output logic [TW-1:0] free_idx,
  output logic [CW-1:0] live_cnt,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  output logic          lk_track
);
  slot_st_e      st_q [ENTRIES];
  slot_st_e      st_d [ENTRIES];
  logic [AW-1:0] addr_q [ENTRIES];
  logic [DW-1:0] data_q [ENTRIES];
  logic [ENTRIES-1:0] m_full, m_wait, m_inv, m_rsp, a_we, d_we;
  logic [TW-1:0] hit_idx;
  logic          iss_kill;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_match
      assign m_full[g] = (st_q[g] == SL_FULL) && (addr_q[g] == lk_addr);
      assign m_wait[g] = (st_q[g] == SL_WAIT) && (addr_q[g] == lk_addr);
      assign m_inv[g]  = inv_valid && (addr_q[g] == inv_addr);
      assign m_rsp[g]  = rsp_valid && (rsp_tag == TW'(g));
    end
  endgenerate

  assign lk_hit   = lk_valid && (m_full != '0);
  assign lk_track = (m_full != '0) || (m_wait != '0);
  assign lk_data  = lk_hit ? data_q[hit_idx] : '0;
  assign iss_kill = flush || (inv_valid && inv_addr == iss_addr);

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    hit_idx  = '0;
    live_cnt = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (st_q[i] == SL_FREE) begin
        free_any = 1'b1;
        free_idx = TW'(i);
      end
      if (m_full[i]) hit_idx = TW'(i);
      if (st_q[i] == SL_WAIT || st_q[i] == SL_FULL) live_cnt = live_cnt + CW'(1);
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_d[i] = st_q[i];
      a_we[i] = 1'b0;
      d_we[i] = 1'b0;
      unique case (st_q[i])
        SL_FREE: if (iss_fire && free_idx == TW'(i)) begin
          a_we[i] = 1'b1;
          st_d[i] = iss_kill ? SL_DROP : SL_WAIT;
        end
        SL_WAIT: begin
          if ((flush || m_inv[i]) && m_rsp[i]) st_d[i] = SL_FREE;
          else if (flush || m_inv[i])          st_d[i] = SL_DROP;
          else if (m_rsp[i]) begin
            st_d[i] = SL_FULL;
            d_we[i] = 1'b1;
          end
        end
        SL_FULL: if ((lk_hit && hit_idx == TW'(i)) || flush || m_inv[i]) st_d[i] = SL_FREE;
        SL_DROP: if (m_rsp[i]) st_d[i] = SL_FREE;
        default: st_d[i] = SL_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= SL_FREE;
    end else begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (a_we[i]) addr_q[i] <= iss_addr;
      if (d_we[i]) data_q[i] <= rsp_data;
    end
  end
endmodule

// File: rtl/spb_stream_buffer.sv
module spb_stream_buffer #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int QDEPTH    = 16,
  parameter int ENTRIES   = 12,
  parameter int LOOKAHEAD = 8,
  localparam int TW       = $clog2(ENTRIES),
  localparam int LCW      = $clog2(ENTRIES + 1),
  localparam int QCW      = $clog2(QDEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          str_valid,
  input  logic [AW-1:0] str_addr,
  output logic          str_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [TW-1:0] req_tag,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  input  logic [DW-1:0] rsp_data,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr
);
  logic           q_full, q_empty, q_probe, free_any, lk_track, flush, iss_fire, push;
  logic [QCW-1:0] q_cnt;
  logic [LCW-1:0] live_cnt;

  assign str_ready = !q_full;
  assign push      = str_valid && str_ready;
  assign req_valid = !q_empty && free_any && (live_cnt < LCW'(LOOKAHEAD));
  assign iss_fire  = req_valid && req_ready;
  // The stream has diverged when a probe finds nothing it predicted.
  assign flush     = lk_valid && !lk_track && !q_probe;

  spb_addr_queue #(.AW(AW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(str_addr),
    .pop(iss_fire), .clear(flush),
    .probe_addr(lk_addr),
    .head_addr(req_addr), .count(q_cnt),
    .full(q_full), .empty(q_empty), .probe_hit(q_probe)
  );

  spb_slot_array #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .iss_fire(iss_fire), .iss_addr(req_addr),
    .flush(flush),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .free_any(free_any), .free_idx(req_tag), .live_cnt(live_cnt),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_track(lk_track)
  );
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int AW        = 32,
  parameter int QDEPTH    = 16,
  parameter int ENTRIES   = 12,
  parameter int LOOKAHEAD = 8,
  localparam int LCW      = $clog2(ENTRIES + 1),
  localparam int QCW      = $clog2(QDEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           str_valid,
  input logic           str_ready,
  input logic           req_valid,
  input logic           lk_valid,
  input logic [AW-1:0]  lk_addr,
  input logic           lk_hit,
  input logic           inv_valid,
  input logic [AW-1:0]  inv_addr,
  input logic           flush,
  input logic [LCW-1:0] live_cnt,
  input logic [QCW-1:0] q_cnt
);
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt <= LCW'(LOOKAHEAD));

  p_issue_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (live_cnt < LCW'(LOOKAHEAD)) && (q_cnt != '0));

  p_ready_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !str_ready |-> q_cnt == QCW'(QDEPTH));

  p_hit_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  p_inv_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_valid) && lk_valid && lk_addr == $past(inv_addr)) |-> !lk_hit);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> q_cnt == QCW'($past(str_valid && str_ready)));
endmodule

bind spb_stream_buffer spb_checker #(
  .AW(AW), .QDEPTH(QDEPTH), .ENTRIES(ENTRIES), .LOOKAHEAD(LOOKAHEAD)
) u_spb_checker (
  .clk(clk), .rst_n(rst_n),
  .str_valid(str_valid), .str_ready(str_ready),
  .req_valid(req_valid),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
  .inv_valid(inv_valid), .inv_addr(inv_addr),
  .flush(flush), .live_cnt(live_cnt), .q_cnt(q_cnt)
);

// File: tb/spb_stream_buffer_bench.sv
module spb_stream_buffer_bench;
  localparam int AW = 32, DW = 64, QD = 16, ENT = 12, LA = 8, TW = 4;

  logic clk, rst_n;
  logic str_valid, str_ready, req_valid, req_ready, rsp_valid, lk_valid, lk_hit, inv_valid;
  logic [AW-1:0] str_addr, req_addr, lk_addr, inv_addr;
  logic [TW-1:0] req_tag, rsp_tag;
  logic [DW-1:0] rsp_data, lk_data;

  spb_stream_buffer u_spb_stream_buffer (
    .clk(clk), .rst_n(rst_n),
    .str_valid(str_valid), .str_addr(str_addr), .str_ready(str_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference state: 0 free, 1 waiting, 2 filled, 3 dropped.
  int            m_st [ENT];
  logic [AW-1:0] m_addr [ENT];
  logic [DW-1:0] m_data [ENT];
  logic [AW-1:0] m_q [$];
  int            o_tag [$];
  logic [AW-1:0] o_addr [$];

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [AW-1:0] next_addr;
  bit e_ready, e_rv, e_hit, e_flush, e_fire, track, qm, kill, rm;
  int e_tag, e_hidx, live, pick;

  function automatic logic [DW-1:0] blk(logic [AW-1:0] a);
    return {a, a ^ 32'h5A5A_5A5A};
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive_idle();
    str_valid = 0; str_addr = '0; req_ready = 0; rsp_valid = 0; rsp_tag = '0;
    rsp_data = '0; lk_valid = 0; lk_addr = '0; inv_valid = 0; inv_addr = '0;
  endtask

  task automatic drive_random();
    int r;
    drive_idle();
    str_valid = ($urandom % 100) < 60;
    str_addr  = next_addr;
    req_ready = ($urandom % 100) < 70;
    if (o_tag.size() > 0 && ($urandom % 10) < 4) begin
      r = $urandom % o_tag.size();
      rsp_valid = 1; rsp_tag = TW'(o_tag[r]); rsp_data = blk(o_addr[r]);
      o_tag.delete(r); o_addr.delete(r);
    end else if (($urandom % 20) == 0) begin
      // R4: a stray response to a slot with nothing outstanding
      r = $urandom % ENT;
      if (!(r inside {o_tag})) begin
        rsp_valid = 1; rsp_tag = TW'(r); rsp_data = 64'hBAD0_BAD0_BAD0_BAD0;
      end
    end
    r = $urandom % 100;
    if (r < 45 || (r >= 45 && r < 55)) begin
      for (int k = 0; k < ENT; k++) begin
        pick = (k + int'($urandom % ENT)) % ENT;
        if (m_st[pick] == ((r < 45) ? 2 : 1)) begin
          lk_valid = 1; lk_addr = m_addr[pick]; break;
        end
      end
    end else if (r < 65 && m_q.size() > 0) begin
      lk_valid = 1; lk_addr = m_q[$urandom % m_q.size()];
    end else if (r < 68) begin
      lk_valid = 1; lk_addr = 32'hF000_0000 | ($urandom % 256);
    end
    if (($urandom % 100) < 6) begin
      pick = $urandom % ENT;
      if (m_st[pick] != 0) begin
        inv_valid = 1; inv_addr = m_addr[pick];
      end else if (req_valid === 1'b1 && ($urandom % 2) == 0) begin
        inv_valid = 1; inv_addr = m_q.size() > 0 ? m_q[0] : '0; // R10 collision
      end
    end
  endtask

  task automatic step_model();
    e_ready = m_q.size() < QD;
    live = 0; e_tag = -1; e_hidx = -1; track = 0; qm = 0;
    for (int i = ENT - 1; i >= 0; i--) begin
      if (m_st[i] == 0) e_tag = i;
      if (m_st[i] == 1 || m_st[i] == 2) live++;
      if (lk_valid && m_st[i] == 2 && m_addr[i] == lk_addr) e_hidx = i;
      if (lk_valid && (m_st[i] == 1 || m_st[i] == 2) && m_addr[i] == lk_addr) track = 1;
    end
    foreach (m_q[j]) if (m_q[j] == lk_addr) qm = 1;
    e_rv    = m_q.size() > 0 && e_tag >= 0 && live < LA;
    e_hit   = e_hidx >= 0;
    e_flush = lk_valid && !track && !qm;
    e_fire  = e_rv && req_ready;

    chk("R9 R8", "str_ready", DW'(str_ready), DW'(e_ready));
    chk("R3 R6", "req_valid", DW'(req_valid), DW'(e_rv));
    if (e_rv) begin
      chk("R2", "req_addr", DW'(req_addr), DW'(m_q[0]));
      chk("R2 R4 R7 R10", "req_tag", DW'(req_tag), DW'(e_tag));
    end
    chk("R5 R7 R8", "lk_hit", DW'(lk_hit), DW'(e_hit));
    if (e_hit) chk("R5 R4", "lk_data", lk_data, m_data[e_hidx]);

    for (int i = 0; i < ENT; i++) begin
      kill = e_flush || (inv_valid && inv_addr == m_addr[i]);
      rm   = rsp_valid && rsp_tag == TW'(i);
      case (m_st[i])
        0: if (e_fire && i == e_tag) begin
             m_addr[i] = m_q[0];
             m_st[i] = (e_flush || (inv_valid && inv_addr == m_q[0])) ? 3 : 1;
           end
        1: if (kill && rm) m_st[i] = 0;
           else if (kill) m_st[i] = 3;
           else if (rm) begin m_st[i] = 2; m_data[i] = rsp_data; end
        2: if ((e_hit && i == e_hidx) || kill) m_st[i] = 0;
        default: if (rm) m_st[i] = 0;
      endcase
    end
    if (e_fire) begin o_tag.push_back(e_tag); o_addr.push_back(m_q[0]); end
    if (e_flush) m_q.delete();
    else if (e_fire) void'(m_q.pop_front());
    if (str_valid && e_ready) begin
      m_q.push_back(str_addr);
      next_addr = next_addr + 32'd64;
    end
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin m_st[i] = 0; m_addr[i] = '0; m_data[i] = '0; end
    next_addr = 32'h0000_1000;
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "str_ready in reset", DW'(str_ready), 64'd1);
    chk("R1", "req_valid in reset", DW'(req_valid), 64'd0);
    chk("R1", "lk_hit in reset", DW'(lk_hit), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_valid after reset", DW'(req_valid), 64'd0);
    // Fill phase: stream only, no fetches, exercises R9 backpressure.
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      drive_idle(); str_valid = 1; str_addr = next_addr;
      #1 step_model();
    end
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      drive_random();
      #1 step_model();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule